// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block collects external interrupt lines, grouped in banks of `LINES` lines, and turns selected signal transitions on them into latched pending flags. Every line first crosses into the block's clock domain through a short synchroniser. Each line has its own rising-transition enable and its own falling-transition enable. With both set, the line reacts to either direction. With neither set, the line never produces a pending flag from its pin. Software can also raise a pending flag directly by writing to a trigger register. A flag stays set until software clears it by writing one to its bit. A single registered interrupt output is high while any pending flag has its enable bit set in the interrupt mask register.

Software reaches every register through a simple valid/ready word port. Writes complete in the cycle they are presented. Read data returns one cycle after the request, marked by `rd_valid`. Banks sit at a stride of 0x20 bytes. Within a bank the word offsets are as follows:

| Offset | Register |
|--------|----------|
| 0x00 | interrupt mask |
| 0x04 | event mask |
| 0x08 | rising enable |
| 0x0C | falling enable |
| 0x10 | software trigger |
| 0x14 | pending |

The four configuration registers (interrupt mask, event mask, rising enable and falling enable) have no hardware reset. Software writes zero to them at start-up.

Top module: `eic_top`

## Requirements
- R1: The interrupt mask (offset 0x00), event mask (0x04), rising enable (0x08) and falling enable (0x0C) of bank b, at byte address b*0x20 + offset, read back the last value written to them. `rd_valid` and `rd_data` appear in the cycle after the read request.
- R2: A 0-to-1 transition on a line whose rising-enable bit is 1 sets that line's bit in the pending register (0x14). Once the synchroniser has been crossed, the bit reads as set.
- R3: A 1-to-0 transition on a line whose falling-enable bit is 1 sets that line's pending bit.
- R4: A line with both enables set gets a pending bit on either transition. A line with neither enable set gets no pending bit from any transition. A transition in a disabled direction also sets no pending bit.
- R5: Writing to the pending register clears each bit written as 1. Bits written as 0 are left unchanged.
- R6: Writing 1 to a bit of the software trigger register (0x10) sets that line's pending bit. The trigger register always reads as zero.
- R7: `irq` is 1 one cycle after some pending bit has its interrupt mask bit at 1, and 0 otherwise. A pending bit whose mask bit is 0 does not raise `irq`, and it raises `irq` once its mask bit is set.
- R8: When a write-one-to-clear and a newly enabled transition reach the same pending bit in the same cycle, the bit stays set.
- R9: Reads return zero for the following addresses, and writes to them change nothing:
  - within-bank offsets 0x18 and 0x1C;
  - a bank index at or above `NB`;
  - an address that is not word-aligned.
- R10: After reset all pending bits are 0, `irq` is 0 and `rd_valid` is 0.
- R11: A pending bit stays set when the line returns to its former level, or makes a further transition. Only a clear write removes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_in | input | NB*LINES | External lines; bank b occupies bits b*LINES and up |
| bus_valid | input | 1 | Register request valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | LINES | Write data |
| bus_ready | output | 1 | Request accepted (high outside reset) |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | LINES | Read data |
| irq | output | 1 | Combined interrupt, registered |

## Verification
Two functions can fall in the same cycle: a clear write to the pending register and a transition detected on the same line. The bench raises an enabled line and counts the two synchroniser stages and the edge stage. It then places a clear write to that bit on exactly the clock edge where the transition is latched. The bit is judged correct only if a later read of the pending register still shows it set. A control clear, issued with no transition present, must then remove the bit.

// File: rtl/eic_pkg.sv
package eic_pkg;
  typedef enum logic [2:0] {
    SEL_IMASK = 3'd0,
    SEL_EMASK = 3'd1,
    SEL_RISE  = 3'd2,
    SEL_FALL  = 3'd3,
    SEL_SWT   = 3'd4,
    SEL_PEND  = 3'd5
  } reg_sel_e;

  localparam int BANK_SPAN_BITS = 5;
  localparam int SEL_LSB        = 2;
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/eic_bank.sv
module eic_bank
  import eic_pkg::*;
#(
  parameter int LINES       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] line_in,
  input  logic             wr_en,
  input  reg_sel_e         wr_sel,
  input  logic [LINES-1:0] wr_data,
  output logic [LINES-1:0] pend,
  output logic [LINES-1:0] imask,
  output logic [LINES-1:0] emask,
  output logic [LINES-1:0] rise,
  output logic [LINES-1:0] fall
);
  logic [LINES-1:0] lvl, lvl_d, hit, sw_set, clr;

  eic_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(line_in), .q(lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= '0;
    else     lvl_d <= lvl;
  end

  // transition detect against the previous synchronised level
  assign hit    = (lvl & ~lvl_d & rise) | (~lvl & lvl_d & fall);
  assign sw_set = (wr_en && wr_sel == SEL_SWT)  ? wr_data : '0;
  assign clr    = (wr_en && wr_sel == SEL_PEND) ? wr_data : '0;

  // a set source wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clr) | hit | sw_set;
  end

  // configuration has no hardware reset; software clears it at start-up
  always_ff @(posedge clk) begin
    if (wr_en) begin
      case (wr_sel)
        SEL_IMASK: imask <= wr_data;
        SEL_EMASK: emask <= wr_data;
        SEL_RISE:  rise  <= wr_data;
        SEL_FALL:  fall  <= wr_data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/eic_top.sv
module eic_top
  import eic_pkg::*;
#(
  parameter int NB          = 2,
  parameter int LINES       = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NB*LINES-1:0] ext_in,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [LINES-1:0]    bus_wdata,
  output logic                bus_ready,
  output logic                rd_valid,
  output logic [LINES-1:0]    rd_data,
  output logic                irq
);
  localparam int BW = ADDR_W - BANK_SPAN_BITS;

  logic [BW-1:0]              bank_idx;
  reg_sel_e                   sel;
  logic                       aligned;
  logic [NB-1:0]              hit_bank;
  logic [NB-1:0][LINES-1:0]   pend_v, imask_v, emask_v, rise_v, fall_v;
  logic [LINES-1:0]           rd_mux;

  assign bank_idx  = bus_addr[ADDR_W-1:BANK_SPAN_BITS];
  assign sel       = reg_sel_e'(bus_addr[BANK_SPAN_BITS-1:SEL_LSB]);
  assign aligned   = (bus_addr[SEL_LSB-1:0] == '0);
  assign bus_ready = ~rst;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign hit_bank[b] = aligned && (bank_idx == BW'(b));

    eic_bank #(.LINES(LINES), .SYNC_STAGES(SYNC_STAGES)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .line_in (ext_in[b*LINES +: LINES]),
      .wr_en   (bus_valid & bus_write & hit_bank[b]),
      .wr_sel  (sel),
      .wr_data (bus_wdata),
      .pend    (pend_v[b]),
      .imask   (imask_v[b]),
      .emask   (emask_v[b]),
      .rise    (rise_v[b]),
      .fall    (fall_v[b])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NB; b++) begin
      if (hit_bank[b]) begin
        case (sel)
          SEL_IMASK: rd_mux = imask_v[b];
          SEL_EMASK: rd_mux = emask_v[b];
          SEL_RISE:  rd_mux = rise_v[b];
          SEL_FALL:  rd_mux = fall_v[b];
          SEL_PEND:  rd_mux = pend_v[b];
          default:   rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      irq      <= 1'b0;
    end else begin
      rd_valid <= bus_valid & ~bus_write;
      rd_data  <= rd_mux;
      irq      <= |(pend_v & imask_v);
    end
  end
endmodule

// File: rtl/eic_chk.sv
module eic_chk #(
  parameter int NB     = 2,
  parameter int LINES  = 32,
  parameter int ADDR_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_valid,
  input logic                bus_write,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                rd_valid,
  input logic [LINES-1:0]    rd_data,
  input logic                irq,
  input logic [NB*LINES-1:0] pend_all,
  input logic [NB*LINES-1:0] mask_all
);
  logic unmapped;
  assign unmapped = (bus_addr[1:0] != 2'b00) || (bus_addr[4:2] > 3'd5) ||
                    (int'(bus_addr[ADDR_W-1:5]) >= NB);

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq == |$past(pend_all & mask_all))); // R7

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rd_valid == $past(bus_valid && !bus_write))); // R1

  AST_SWT_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(bus_addr[4:2]) == 3'd4) |-> (rd_data == '0)); // R6

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(unmapped)) |-> (rd_data == '0)); // R9

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bus_valid && bus_write)) |->
      ((pend_all & $past(pend_all)) == $past(pend_all))); // R11

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pend_all == '0 && !irq && !rd_valid)); // R10
endmodule

bind eic_top eic_chk #(.NB(NB), .LINES(LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq),
  .pend_all(pend_v), .mask_all(imask_v)
);

// File: tb/sim_eic_top.sv
module sim_eic_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 2;
  localparam int LINES = 32;
  localparam int ADDR_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NB*LINES-1:0] ext_in = '0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [LINES-1:0] bus_wdata = '0;
  logic bus_ready, rd_valid, irq;
  logic [LINES-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { logic [LINES-1:0] exp; string tag; } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  eic_top #(.NB(NB), .LINES(LINES), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst(rst), .ext_in(ext_in), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq)
  );

  function automatic logic [ADDR_W-1:0] ra(int b, int off);
    return ADDR_W'(b * 32 + off * 4);
  endfunction

  task automatic check(string tag, logic [LINES-1:0] act, logic [LINES-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [ADDR_W-1:0] a, logic [LINES-1:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(logic [ADDR_W-1:0] a, logic [LINES-1:0] exp, string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor: compares every returned read against the scoreboard
  always @(negedge clk) begin
    if (!rst && rd_valid && !done) begin
      if (sb.size() == 0) begin
        check("R1 unexpected read data", 32'h1, 32'h0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(it.tag, rd_data, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle(5);
    rst = 1'b0;
    idle(1);
    check("R10 irq after reset", {31'd0, irq}, 32'd0);
    check("R10 rd_valid after reset", {31'd0, rd_valid}, 32'd0);
    check("R10 bus_ready", {31'd0, bus_ready}, 32'd1);
    bus_rd(ra(0, 5), 32'h0, "R10 pend b0 after reset");
    bus_rd(ra(1, 5), 32'h0, "R10 pend b1 after reset");

    // start-up clear of configuration
    for (int b = 0; b < NB; b++)
      for (int o = 0; o < 4; o++) bus_wr(ra(b, o), 32'h0);

    // R1 register readback
    bus_wr(ra(0, 2), 32'h0000_0003);
    bus_wr(ra(0, 3), 32'h0000_0006);
    bus_wr(ra(1, 1), 32'hDEAD_BEEF);
    bus_wr(ra(1, 0), 32'h5A5A_5A5A);
    bus_rd(ra(0, 2), 32'h0000_0003, "R1 rise b0");
    bus_rd(ra(0, 3), 32'h0000_0006, "R1 fall b0");
    bus_rd(ra(1, 1), 32'hDEAD_BEEF, "R1 event mask b1");
    bus_rd(ra(1, 0), 32'h5A5A_5A5A, "R1 imask b1");
    bus_rd(ra(0, 0), 32'h0, "R1 imask b0 untouched");
    bus_wr(ra(1, 0), 32'h0);

    // R2 rising on line0; line3 has no enable (R4)
    ext_in[0] = 1'b1; ext_in[3] = 1'b1;
    idle(5);
    bus_rd(ra(0, 5), 32'h1, "R2 rising sets pend, R4 line3 none");
    // R11 line0 falls but only rise enabled
    ext_in[0] = 1'b0; ext_in[3] = 1'b0;
    idle(5);
    bus_rd(ra(0, 5), 32'h1, "R11 pend held after return");
    // R3 line2 falling only
    ext_in[2] = 1'b1;
    idle(5);
    bus_rd(ra(0, 5), 32'h1, "R4 rise on fall-only line ignored");
    ext_in[2] = 1'b0;
    idle(5);
    bus_rd(ra(0, 5), 32'h5, "R3 falling sets pend");
    // R4 line1 both edges
    ext_in[1] = 1'b1;
    idle(5);
    bus_rd(ra(0, 5), 32'h7, "R4 both: rising");
    bus_wr(ra(0, 5), 32'h2);
    bus_rd(ra(0, 5), 32'h5, "R5 clear bit1");
    ext_in[1] = 1'b0;
    idle(5);
    bus_rd(ra(0, 5), 32'h7, "R4 both: falling");
    // R5 write-one-to-clear
    bus_wr(ra(0, 5), 32'h0);
    bus_rd(ra(0, 5), 32'h7, "R5 zero write keeps");
    bus_wr(ra(0, 5), 32'h5);
    bus_rd(ra(0, 5), 32'h2, "R5 partial clear");
    bus_wr(ra(0, 5), 32'h2);
    bus_rd(ra(0, 5), 32'h0, "R5 full clear");

    // R6 / R7 software trigger with mask
    bus_wr(ra(0, 4), 32'h10);
    bus_rd(ra(0, 5), 32'h10, "R6 sw trigger sets pend");
    bus_rd(ra(0, 4), 32'h0, "R6 trigger reads zero");
    idle(2);
    check("R7 masked pend no irq", {31'd0, irq}, 32'd0);
    bus_wr(ra(0, 0), 32'h10);
    idle(1);
    check("R7 unmask raises irq", {31'd0, irq}, 32'd1);
    bus_wr(ra(0, 5), 32'h10);
    idle(1);
    check("R7 clear drops irq", {31'd0, irq}, 32'd0);
    bus_wr(ra(1, 0), 32'h8000_0000);
    bus_wr(ra(1, 4), 32'h8000_0000);
    idle(1);
    check("R7 bank1 irq", {31'd0, irq}, 32'd1);
    bus_rd(ra(1, 5), 32'h8000_0000, "R6 bank1 pend");
    bus_wr(ra(1, 5), 32'h8000_0000);
    idle(1);
    check("R7 bank1 clear", {31'd0, irq}, 32'd0);

    // R8 clear and enabled transition on the same edge
    bus_wr(ra(0, 4), 32'h1);
    ext_in[0] = 1'b1;          // sampled by stage one next edge
    idle(2);                   // second stage and edge stage ready
    bus_wr(ra(0, 5), 32'h1);   // lands on the latching edge
    bus_rd(ra(0, 5), 32'h1, "R8 set wins over clear");
    bus_wr(ra(0, 5), 32'h1);
    bus_rd(ra(0, 5), 32'h0, "R8 control clear");

    // R9 unmapped addresses
    bus_wr(8'h18, 32'hFFFF_FFFF);
    bus_wr(8'h01, 32'hFFFF_FFFF);
    bus_rd(8'h18, 32'h0, "R9 offset 0x18");
    bus_rd(8'h1C, 32'h0, "R9 offset 0x1C");
    bus_rd(8'h40, 32'h0, "R9 bank beyond NB");
    bus_rd(8'h01, 32'h0, "R9 misaligned");
    bus_rd(ra(0, 0), 32'h10, "R9 writes changed nothing");
    bus_rd(ra(0, 5), 32'h0, "R9 pend untouched");

    idle(3);
    if (sb.size() != 0) check("R1 reads outstanding", 32'(sb.size()), 32'd0);
    finish_run();
  end
endmodule